// File: doc/BRIEF.md
# PLL Power Sequencer

This block owns the control word of one phase-locked loop and walks it through safe power-up and power-down sequences when asked. An enable request hands the root clock over to the reference input (when this PLL feeds the CPU root), loads the ratio factors with the loop powered, pulses the loop's reset, and polls the lock field, raising a clear-slip strobe after each failed poll. Only after lock does it release bypass and assert the output enable, and then it gives the root clock back. A disable request first bypasses the loop and only later removes power and enable, so downstream logic always has a running clock.

The block also reports the frequency that the current control word produces, as a registered value computed from the reference frequency and the packed factors. The analog loop is not part of the block. Its lock field arrives as an input, and the clear-slip strobe leaves as a write vector aligned to the lock status word.

Top module: `pll_seq_ctrl`

## Requirements
- R1: During reset the control word is 0x0080_0000 (only bypass, bit 23, set). `busy`, `done`, `err`, `root_force_ref` and `slip_wr` are all zero. One clock after reset ends, `freq_hz` equals `ref_hz`.
- R2: An enable request while the loop already runs (reset bit 20 low, power bit 21 and enable bit 25 both set) pulses `done` in the next cycle. It writes nothing to the control word and never raises `busy`.
- R3: A start sequence writes the control word in this order. First it loads the factors into bits 19:0 (ref divider 3:0, multiplier 9:4, output divider 13:10, bandwidth 19:14) with power set and bypass kept. Then it holds reset low, raises reset for exactly RST_HOLD cycles, and lowers it again.
- R4: After the reset pulse the lock field is polled until every bit is one. Each failed poll pulses bit LOCK_BASE+2 of `slip_wr` in the following cycle, and no other bit. A partly set field counts as a miss.
- R5: On lock, bypass is cleared and enable is set in one control-word update. `done` pulses one cycle later.
- R6: With CPU_ROOT=1, `root_force_ref` rises together with `busy` at the start of an enable sequence. It stays high until the cycle in which `done` reports a successful start.
- R7: A disable request first sets bypass, then in a later, separate update clears power and enable. `done` pulses with the second update.
- R8: `freq_hz` follows the control word one cycle later. It is `ref_hz` when bypass is set, 0 when power is clear, and otherwise ref × (F+1) / ((R+1) × (OD+1)).
- R9: If the lock field is not all ones within LOCK_TIMEOUT polls, `err` pulses for one cycle without `done` and the block returns to idle. Bypass is still set, enable is still clear, and `root_force_ref` stays high.
- R10: Enable and disable requests that arrive while `busy` is high are ignored. The running sequence keeps the factors that were latched when it started.
- R11: When enable and disable are requested in the same idle cycle, enable wins.
- R12: Bits 27:26 of the control word carry `src_sel` only when HAS_SRC_SEL=1. With the default HAS_SRC_SEL=0 they stay zero whatever `src_sel` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_req | input | 1 | Start-up request |
| dis_req | input | 1 | Shut-down request |
| fac_r | input | 4 | Reference divider minus one |
| fac_f | input | 6 | Feedback multiplier minus one |
| fac_od | input | 4 | Output divider minus one |
| fac_bw | input | 6 | Bandwidth adjust |
| src_sel | input | 2 | Loop input source select (used when HAS_SRC_SEL=1) |
| lock_field | input | LOCK_W | Lock status bits of this loop |
| ref_hz | input | FREQ_W | Reference input frequency in Hz |
| ctl_reg | output | 32 | Packed loop control word |
| slip_wr | output | LOCK_REG_W | Clear-slip write vector aligned to the lock status word |
| root_force_ref | output | 1 | Forces the root clock selector to the reference input |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse on lock timeout |
| freq_hz | output | FREQ_W | Computed output frequency |

## Verification
The assertions assume that `lock_field` never reports lock while the loop is held in reset or unpowered. They also assume that `ref_hz` and the factors stay steady while a sequence is running. The bench's lock model clears its counter whenever reset is high or power is low. It keeps `ref_hz` fixed for the whole run and changes the factors only between sequences, apart from the one deliberate mid-sequence change used for R10. The request pulses are driven half a cycle away from the sampling edge, so each is seen in exactly one cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int CTL_W = 32;
  localparam int B_RST = 20;
  localparam int B_PWR = 21;
  localparam int B_BYP = 23;
  localparam int B_EN  = 25;
  localparam int B_SRC = 26;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h0080_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_RLO, S_RHI, S_RHOLD, S_POLL, S_FIN, S_DBYP, S_DOFF
  } seq_st_t;

  typedef struct packed {
    logic [1:0] src;
    logic [5:0] bw;
    logic [3:0] od;
    logic [5:0] f;
    logic [3:0] r;
  } pll_fac_t;

  // loop is considered up: out of reset, powered, output enabled
  function automatic logic is_running(logic [CTL_W-1:0] c);
    return !c[B_RST] && c[B_PWR] && c[B_EN];
  endfunction

  function automatic logic [CTL_W-1:0] load_factors(logic [CTL_W-1:0] cur, pll_fac_t fa,
                                                    logic use_src);
    logic [CTL_W-1:0] v;
    v = cur;
    v[19:0] = {fa.bw, fa.od, fa.f, fa.r};
    v[B_PWR] = 1'b1;
    if (use_src) v[B_SRC+1:B_SRC] = fa.src;
    return v;
  endfunction

  function automatic logic [63:0] out_hz(logic [63:0] ref_hz, logic [CTL_W-1:0] c);
    logic [63:0] num, den;
    if (c[B_BYP]) return ref_hz;
    if (!c[B_PWR]) return 64'd0;
    num = ref_hz * (64'(c[9:4]) + 64'd1);
    den = (64'(c[3:0]) + 64'd1) * (64'(c[13:10]) + 64'd1);
    return num / den;
  endfunction
endpackage

// File: rtl/pll_lock_mon.sv
module pll_lock_mon #(
  parameter int LOCK_REG_W = 32,
  parameter int LOCK_BASE  = 0,
  parameter int LOCK_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LOCK_W-1:0]     lock_field,
  input  logic                  slip_req,
  output logic                  locked,
  output logic [LOCK_REG_W-1:0] slip_wr
);
  localparam int SLIP_BIT = LOCK_BASE + 2;

  logic slip_q;

  assign locked = &lock_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slip_q <= 1'b0;
    else        slip_q <= slip_req;
  end

  for (genvar i = 0; i < LOCK_REG_W; i++) begin : g_slip
    if (i == SLIP_BIT) begin : g_hit
      assign slip_wr[i] = slip_q;
    end else begin : g_zero
      assign slip_wr[i] = 1'b0;
    end
  end

  assert_slip_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slip_wr));
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_seq_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [CTL_W-1:0]  ctl,
  output logic [FREQ_W-1:0] freq_hz
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_hz <= '0;
    else        freq_hz <= FREQ_W'(out_hz(64'(ref_hz), ctl));
  end

  assert_bypass_gives_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[B_BYP] && $stable(ref_hz)) |=> (freq_hz == $past(ref_hz)));
  assert_unpowered_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[B_BYP] && !ctl[B_PWR]) |=> (freq_hz == '0));
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CPU_ROOT     = 1,
  parameter int HAS_SRC_SEL  = 0,
  parameter int RST_HOLD     = 2,
  parameter int LOCK_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             dis_req,
  input  pll_fac_t         fac_in,
  input  logic             locked,
  output logic [CTL_W-1:0] ctl,
  output logic             slip_req,
  output logic             force_ref,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int HW = $clog2(RST_HOLD + 1);
  localparam int TW = $clog2(LOCK_TIMEOUT + 1);

  seq_st_t          st_q;
  logic [CTL_W-1:0] ctl_q;
  pll_fac_t         fac_q;
  logic [HW-1:0]    hold_q;
  logic [TW-1:0]    tmo_q;
  logic             force_q, done_q, err_q;
  logic [CTL_W-1:0] load_val;

  // named internal events
  logic ev_fast_done, ev_start, ev_stop, ev_lock_ok, ev_timeout;

  always_comb begin
    ev_fast_done = (st_q == S_IDLE) && en_req && is_running(ctl_q);
    ev_start     = (st_q == S_IDLE) && en_req && !is_running(ctl_q);
    ev_stop      = (st_q == S_IDLE) && !en_req && dis_req;
    ev_lock_ok   = (st_q == S_POLL) && locked;
    ev_timeout   = (st_q == S_POLL) && !locked && (tmo_q == TW'(LOCK_TIMEOUT - 1));
  end

  if (HAS_SRC_SEL != 0) begin : g_src
    assign load_val = load_factors(ctl_q, fac_q, 1'b1);
  end else begin : g_nosrc
    assign load_val = load_factors(ctl_q, fac_q, 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ctl_q   <= CTL_RESET;
      fac_q   <= '0;
      hold_q  <= '0;
      tmo_q   <= '0;
      force_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (ev_fast_done) done_q <= 1'b1;
          else if (ev_start) begin
            fac_q   <= fac_in;
            force_q <= (CPU_ROOT != 0);
            st_q    <= S_LOAD;
          end else if (ev_stop) st_q <= S_DBYP;
        end
        S_LOAD: begin
          ctl_q <= load_val;
          st_q  <= S_RLO;
        end
        S_RLO: begin
          ctl_q[B_RST] <= 1'b0;
          st_q         <= S_RHI;
        end
        S_RHI: begin
          ctl_q[B_RST] <= 1'b1;
          hold_q       <= HW'(1);
          st_q         <= S_RHOLD;
        end
        S_RHOLD: begin
          if (hold_q == HW'(RST_HOLD)) begin
            ctl_q[B_RST] <= 1'b0;
            tmo_q        <= '0;
            st_q         <= S_POLL;
          end else hold_q <= hold_q + HW'(1);
        end
        S_POLL: begin
          if (ev_lock_ok) begin
            ctl_q[B_BYP] <= 1'b0;
            ctl_q[B_EN]  <= 1'b1;
            st_q         <= S_FIN;
          end else if (ev_timeout) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else tmo_q <= tmo_q + TW'(1);
        end
        S_FIN: begin
          force_q <= 1'b0;
          done_q  <= 1'b1;
          st_q    <= S_IDLE;
        end
        S_DBYP: begin
          ctl_q[B_BYP] <= 1'b1;
          st_q         <= S_DOFF;
        end
        S_DOFF: begin
          ctl_q[B_PWR] <= 1'b0;
          ctl_q[B_EN]  <= 1'b0;
          done_q       <= 1'b1;
          st_q         <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ctl       = ctl_q;
  assign slip_req  = (st_q == S_POLL) && !locked;
  assign force_ref = force_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  assert_reset_pulse_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_RST]) |-> (ctl_q[B_PWR] && ctl_q[B_BYP] && !ctl_q[B_EN]));
  assert_enable_drops_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_EN]) |-> $fell(ctl_q[B_BYP]));
  assert_bypass_before_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[B_PWR]) |-> ($past(ctl_q[B_BYP]) && ctl_q[B_BYP]));
  assert_timeout_bypassed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ctl_q[B_BYP] && !ctl_q[B_EN] && !done_q));
  assert_start_from_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_req || dis_req));

  if (CPU_ROOT != 0) begin : g_root_chk
    assert_root_forced_at_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[B_EN]) |-> force_q);
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int CPU_ROOT     = 1,
  parameter int HAS_SRC_SEL  = 0,
  parameter int RST_HOLD     = 2,
  parameter int LOCK_TIMEOUT = 64,
  parameter int LOCK_REG_W   = 32,
  parameter int LOCK_BASE    = 0,
  parameter int LOCK_W       = 2,
  parameter int FREQ_W       = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_req,
  input  logic                  dis_req,
  input  logic [3:0]            fac_r,
  input  logic [5:0]            fac_f,
  input  logic [3:0]            fac_od,
  input  logic [5:0]            fac_bw,
  input  logic [1:0]            src_sel,
  input  logic [LOCK_W-1:0]     lock_field,
  input  logic [FREQ_W-1:0]     ref_hz,
  output logic [31:0]           ctl_reg,
  output logic [LOCK_REG_W-1:0] slip_wr,
  output logic                  root_force_ref,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [FREQ_W-1:0]     freq_hz
);
  pll_fac_t fac_w;
  logic     locked_w, slip_req_w;

  assign fac_w = '{src: src_sel, bw: fac_bw, od: fac_od, f: fac_f, r: fac_r};

  pll_seq_fsm #(
    .CPU_ROOT(CPU_ROOT), .HAS_SRC_SEL(HAS_SRC_SEL),
    .RST_HOLD(RST_HOLD), .LOCK_TIMEOUT(LOCK_TIMEOUT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .fac_in(fac_w), .locked(locked_w), .ctl(ctl_reg), .slip_req(slip_req_w),
    .force_ref(root_force_ref), .busy(busy), .done(done), .err(err)
  );

  pll_lock_mon #(
    .LOCK_REG_W(LOCK_REG_W), .LOCK_BASE(LOCK_BASE), .LOCK_W(LOCK_W)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_field(lock_field), .slip_req(slip_req_w),
    .locked(locked_w), .slip_wr(slip_wr)
  );

  pll_freq_calc #(.FREQ_W(FREQ_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .ref_hz(ref_hz), .ctl(ctl_reg), .freq_hz(freq_hz)
  );

  assert_slip_only_while_bypassed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_wr != '0) |-> (ctl_reg[B_BYP] && !ctl_reg[B_EN]));
  assert_done_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

// File: tb/sim_pll_seq_ctrl.sv
module sim_pll_seq_ctrl;
  localparam int RST_HOLD = 2;
  localparam int TMO      = 64;
  localparam int LOCK_DLY = 12;
  localparam logic [31:0] REF = 32'd26_000_000;
  localparam logic [31:0] RSTB = 32'h0010_0000, PWRB = 32'h0020_0000;
  localparam logic [31:0] BYPB = 32'h0080_0000, ENB = 32'h0200_0000;

  logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, dis_req = 1'b0;
  logic [3:0] fac_r = '0, fac_od = '0;
  logic [5:0] fac_f = '0, fac_bw = '0;
  logic [1:0] src_sel = 2'b11;
  logic [1:0] lock_field = '0;
  logic [31:0] ref_hz = REF;
  logic [31:0] ctl_reg, slip_wr, freq_hz;
  logic root_force_ref, busy, done, err;

  int n_chk = 0, n_fail = 0;
  bit lock_en = 1'b1;
  logic [31:0] exp_q[$];
  logic [31:0] model = 32'h0080_0000;

  always #5 clk = ~clk;

  pll_seq_ctrl #(.RST_HOLD(RST_HOLD), .LOCK_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .fac_r(fac_r), .fac_f(fac_f), .fac_od(fac_od), .fac_bw(fac_bw),
    .src_sel(src_sel), .lock_field(lock_field), .ref_hz(ref_hz),
    .ctl_reg(ctl_reg), .slip_wr(slip_wr), .root_force_ref(root_force_ref),
    .busy(busy), .done(done), .err(err), .freq_hz(freq_hz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_freq(logic [31:0] c);
    longint unsigned v;
    if (c[23]) return REF;
    if (!c[21]) return 0;
    v = longint'(REF) * (longint'(c[9:4]) + 1);
    v = v / (longint'(c[3:0]) + 1);
    v = v / (longint'(c[13:10]) + 1);
    return v[31:0];
  endfunction

  task automatic push(input logic [31:0] v);
    if (v != model) begin
      exp_q.push_back(v);
      model = v;
    end
  endtask

  // delayed-lock model: bit 0 settles three cycles before bit 1
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!lock_en || ctl_reg[20] || !ctl_reg[21]) cnt = 0;
      else if (cnt < 1000) cnt++;
      lock_field = {cnt >= LOCK_DLY, cnt >= LOCK_DLY - 3};
    end
  end

  // scoreboard monitor: every control-word change must match the queue head
  initial begin
    logic [31:0] seen = 32'h0080_0000;
    forever begin
      @(negedge clk);
      if (rst_n && ctl_reg != seen) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected control write", ctl_reg, seen);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(ctl_reg == e, "R3 control write order", ctl_reg, e);
        end
        seen = ctl_reg;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic do_enable(input logic [3:0] r, input logic [5:0] f, input logic [3:0] od,
                           input logic [5:0] bw, input bit expect_lock, input bit with_dis,
                           input bit inject);
    logic [31:0] v1;
    int rst_hi = 0, slips = 0;
    bit saw_done = 0, saw_err = 0, bad_slip = 0;
    v1 = (model & ~32'h000F_FFFF) | {12'd0, bw, od, f, r} | PWRB;
    push(v1); push(v1 | RSTB); push(v1);
    if (expect_lock) push((v1 & ~BYPB) | ENB);
    fac_r = r; fac_f = f; fac_od = od; fac_bw = bw;
    en_req = 1'b1; dis_req = with_dis;
    tick();
    en_req = 1'b0; dis_req = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    chk(root_force_ref == 1'b1, "R6 root forced at start", root_force_ref, 1);
    for (int c = 0; c < 400; c++) begin
      if (ctl_reg[20]) rst_hi++;
      if (slip_wr == 32'h4) slips++;
      else if (slip_wr != 0) bad_slip = 1;
      if (done) saw_done = 1;
      if (err) saw_err = 1;
      if (done || err) break;
      if (inject && c == 3) begin
        en_req = 1'b1; dis_req = 1'b1; fac_r = 4'hF; fac_f = 6'h3F; fac_od = 4'hF;
      end
      if (inject && c == 4) begin en_req = 1'b0; dis_req = 1'b0; end
      tick();
    end
    chk(rst_hi == RST_HOLD, "R3 reset hold cycles", rst_hi, RST_HOLD);
    chk(!bad_slip, "R4 slip only on bit 2", bad_slip, 0);
    if (expect_lock) begin
      chk(saw_done && !saw_err, "R5 done after lock", {saw_done, saw_err}, 2'b10);
      chk(slips >= LOCK_DLY - 2 && slips <= LOCK_DLY, "R4 slip count waits for all lock bits",
          slips, LOCK_DLY - 1);
      chk(ctl_reg[25] && !ctl_reg[23], "R5 enable set, bypass clear", ctl_reg, (v1 & ~BYPB) | ENB);
      chk(root_force_ref == 1'b0, "R6 root handed back with done", root_force_ref, 0);
      chk(ctl_reg[19:0] == {bw, od, f, r}, "R10 factors latched at start", ctl_reg[19:0],
          {bw, od, f, r});
      chk(freq_hz == exp_freq(ctl_reg), "R8 running frequency", freq_hz, exp_freq(ctl_reg));
    end else begin
      chk(saw_err && !saw_done, "R9 err without done", {saw_done, saw_err}, 2'b01);
      chk(slips == TMO, "R4 one slip per failed poll", slips, TMO);
      chk(ctl_reg[23] && !ctl_reg[25], "R9 still bypassed", ctl_reg, v1);
      chk(root_force_ref == 1'b1, "R9 root stays forced", root_force_ref, 1);
      tick();
      chk(!err && !busy, "R9 err is one pulse, idle", {err, busy}, 0);
      chk(freq_hz == REF, "R8 bypass frequency", freq_hz, REF);
    end
    chk(ctl_reg[27:26] == 2'b00, "R12 source bits unused", ctl_reg[27:26], 0);
  endtask

  task automatic do_disable();
    bit saw = 0;
    push(model | BYPB);
    push(model & ~(PWRB | ENB));
    dis_req = 1'b1;
    tick();
    dis_req = 1'b0;
    chk(busy == 1'b1, "R7 busy during shut-down", busy, 1);
    for (int c = 0; c < 10; c++) begin
      if (done) begin saw = 1; break; end
      chk(ctl_reg[21] == 1'b1 || ctl_reg[23] == 1'b1, "R7 bypass before power off", ctl_reg, BYPB);
      tick();
    end
    chk(saw, "R7 done pulse", saw, 1);
    chk(!ctl_reg[21] && !ctl_reg[25] && ctl_reg[23], "R7 final state", ctl_reg, model);
    tick();
    chk(freq_hz == REF, "R8 frequency after shut-down", freq_hz, REF);
  endtask

  initial begin
    repeat (3) tick();
    chk(ctl_reg == 32'h0080_0000, "R1 reset control word", ctl_reg, 32'h0080_0000);
    chk({busy, done, err, root_force_ref} == 4'b0 && slip_wr == 0, "R1 reset status",
        {busy, done, err, root_force_ref}, 0);
    rst_n = 1'b1;
    tick();
    chk(freq_hz == REF, "R1 frequency after reset", freq_hz, REF);

    do_enable(4'd0, 6'd59, 4'd1, 6'd59, 1, 0, 0);

    en_req = 1'b1;
    tick();
    en_req = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R2 fast done when running", {done, busy}, 2'b10);
    tick();
    chk(done == 1'b0 && busy == 1'b0, "R2 no sequence started", {done, busy}, 0);

    do_disable();

    lock_en = 1'b0;
    do_enable(4'd1, 6'd15, 4'd3, 6'd15, 0, 0, 0);
    lock_en = 1'b1;

    do_enable(4'd1, 6'd15, 4'd3, 6'd16, 1, 1, 1);
    chk(freq_hz == 32'd52_000_000, "R8 second ratio", freq_hz, 32'd52_000_000);
    chk(ctl_reg[25], "R11 enable wins over disable", ctl_reg[25], 1);

    do_disable();
    repeat (3) tick();
    chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule